// File: doc/BRIEF.md
# Burst-Read Scratch Buffer with Paired Host Writes

This block is a scratch memory of 16-bit fixed-point words, sized by default at 256 entries. It holds the matrices and vectors an accelerator works on: inputs, weights, bias vectors and stored activations. The host fills it through two write channels. Each channel has its own valid flag and data word. Both channels share one internal write pointer. The pointer starts at zero after reset and advances by the number of words written in each cycle. When both channels are valid in the same cycle, channel 1 takes the lower of the two consecutive addresses.

Reads are bursts. One command carries a start address, a row count, a column count, an order flag and a destination tag. After that command the read engine streams the words by itself until the whole rows × cols block has been delivered. The walk is row-major by default. With the order flag set it is column-major, which hands the block to the consumer transposed. Each word carries the destination tag. A separate output flags words bound for the bias input of the vector unit.

Top module: `ub_burst_buffer`

## Requirements
- R1: After reset, rd_valid, rd_done, rd_busy and rd_to_bias are all 0.
- R2: A cycle in which exactly one write channel is valid stores that channel's word at the write pointer. The pointer then advances by one. The pointer is 0 after reset and wraps modulo the depth.
- R3: A cycle in which both channels are valid stores wr1_data at pointer p and wr2_data at p+1, modulo the depth. The pointer then advances by two.
- R4: A start accepted at clock edge E0 (rd_start high while rd_busy is low) delivers burst word k with rd_valid high in the cycle after edge E0+k+1. No word is delivered while no burst is running.
- R5: With rd_transpose = 0, the words come in the order r outer, c inner. Each word is the content of address base + r·cols + c.
- R6: With rd_transpose = 1, the words come in the order c outer, r inner. The address of each word is the same as in R5.
- R7: A burst delivers exactly rows × cols words. rd_rows is an 8-bit count. rd_cols is a 2-bit count: 0 means zero columns and 3 means three. A burst with zero rows or zero columns delivers no word.
- R8: rd_done is high for one cycle, one cycle after the last word of a burst. For an empty burst it is high in the cycle after edge E0+1. It is never high together with rd_valid.
- R9: A start that arrives while rd_busy is high has no effect. The running stream is unchanged and no extra burst follows it.
- R10: Each delivered word carries the 3-bit tag given at its start on rd_tag. rd_to_bias is high exactly when rd_valid is high and the tag is 001.
- R11: Read addresses wrap modulo the depth, so a burst may run past the top entry into entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr1_valid | input | 1 | Write channel 1 carries a word this cycle |
| wr1_data | input | 16 | Write channel 1 word |
| wr2_valid | input | 1 | Write channel 2 carries a word this cycle |
| wr2_data | input | 16 | Write channel 2 word |
| rd_start | input | 1 | Launch a burst read when the engine is idle |
| rd_base | input | 8 | Burst start address |
| rd_rows | input | 8 | Number of rows in the burst |
| rd_cols | input | 2 | Number of columns in the burst (0 to 3) |
| rd_transpose | input | 1 | 1 = column-major walk, 0 = row-major walk |
| rd_sel | input | 3 | Destination tag for the burst |
| rd_busy | output | 1 | A burst is issuing addresses |
| rd_valid | output | 1 | rd_data holds a burst word |
| rd_data | output | 16 | Burst word |
| rd_tag | output | 3 | Tag of the current word |
| rd_to_bias | output | 1 | Current word is bound for the bias input |
| rd_done | output | 1 | One-cycle pulse after a burst ends |

## Verification
A write becomes readable in the cycle after the clock edge that takes it. The bench therefore reads only after the writes have settled. For a start taken at edge E0, word k is due after edge E0+k+1 and rd_done after edge E0+N+1, where N is rows × cols. That gives the same formula for empty bursts. The bench drives inputs on falling edges. After the accepting edge it samples once per falling edge, so sample k lands exactly on word k. The next sample must show the done pulse with rd_valid low, and the one after it must show both low.

// File: rtl/ub_pkg.sv
package ub_pkg;
   // tag value that routes a read stream to the bias input of the vector unit
   localparam logic [2:0] TAG_BIAS = 3'b001;

   typedef enum logic [0:0] {
      WALK_ROWS = 1'b0,
      WALK_COLS = 1'b1
   } walk_e;
endpackage

// File: rtl/ub_wr_arbiter.sv
module ub_wr_arbiter #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16,
   parameter int WR_CH  = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [WR_CH-1:0]               ch_valid,
   input  logic [WR_CH-1:0][DATA_W-1:0]   ch_data,
   output logic [WR_CH-1:0]               we,
   output logic [WR_CH-1:0][ADDR_W-1:0]   waddr,
   output logic [WR_CH-1:0][DATA_W-1:0]   wdata
);
   if (WR_CH < 1) begin : g_bad_ch
      $error("ub_wr_arbiter: WR_CH must be at least 1");
   end

   logic [ADDR_W-1:0] ptr_q;
   logic [ADDR_W-1:0] ptr_nx;

   // lower channel index takes the lower address of a multi-word cycle
   always_comb begin
      logic [ADDR_W-1:0] run;
      run = ptr_q;
      for (int i = 0; i < WR_CH; i++) begin
         waddr[i] = run;
         if (ch_valid[i]) run = run + 1'b1;
      end
      ptr_nx = run;
   end

   assign we    = ch_valid;
   assign wdata = ch_data;

   always_ff @(posedge clk) begin
      if (!rst_n) ptr_q <= '0;
      else        ptr_q <= ptr_nx;
   end

   if (WR_CH == 2) begin : g_pair_chk
      assert_pair_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (&ch_valid) |=> (ptr_q == ADDR_W'($past(ptr_q) + ADDR_W'(2))));
   end
   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_valid == '0) |=> $stable(ptr_q));
endmodule

// File: rtl/ub_mem.sv
module ub_mem #(
   parameter int DEPTH  = 256,
   parameter int DATA_W = 16,
   parameter int WR_CH  = 2,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic                           clk,
   input  logic [WR_CH-1:0]               we,
   input  logic [WR_CH-1:0][ADDR_W-1:0]   waddr,
   input  logic [WR_CH-1:0][DATA_W-1:0]   wdata,
   input  logic                           re,
   input  logic [ADDR_W-1:0]              raddr,
   output logic [DATA_W-1:0]              rdata
);
   if (DEPTH < 2 || (1 << ADDR_W) != DEPTH) begin : g_bad_depth
      $error("ub_mem: DEPTH must be a power of two of at least 2");
   end

   logic [DATA_W-1:0] store [DEPTH];
   logic [DATA_W-1:0] rdata_q;

   always_ff @(posedge clk) begin
      for (int i = 0; i < WR_CH; i++) begin
         if (we[i]) store[waddr[i]] <= wdata[i];
      end
      if (re) rdata_q <= store[raddr];
   end

   assign rdata = rdata_q;
endmodule

// File: rtl/ub_rd_seq.sv
module ub_rd_seq #(
   parameter int ADDR_W          = 8,
   parameter int ROW_W           = 8,
   parameter int COL_W           = 2,
   parameter int SEL_W           = 3,
   parameter bit ALLOW_TRANSPOSE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] base,
   input  logic [ROW_W-1:0]  rows,
   input  logic [COL_W-1:0]  cols,
   input  logic              transpose,
   input  logic [SEL_W-1:0]  sel,
   output logic              busy,
   output logic              issue,
   output logic [ADDR_W-1:0] iaddr,
   output logic              valid,
   output logic [SEL_W-1:0]  tag,
   output logic              done
);
   localparam int OFF_W = ROW_W + COL_W;

   if (ROW_W < 1 || COL_W < 1 || SEL_W < 1) begin : g_bad_w
      $error("ub_rd_seq: widths must be positive");
   end

   logic              busy_q, valid_q, pend_q, done_q;
   logic [ROW_W-1:0]  row_q, rows_q, row_nx;
   logic [COL_W-1:0]  col_q, cols_q, col_nx;
   logic [ADDR_W-1:0] base_q;
   logic [SEL_W-1:0]  sel_q, tag_q;
   ub_pkg::walk_e     walk_q, walk_eff;
   logic              row_end, col_end, last, accept, empty;
   logic [OFF_W-1:0]  off;

   if (ALLOW_TRANSPOSE) begin : g_walk
      assign walk_eff = walk_q;
   end else begin : g_rows_only
      assign walk_eff = ub_pkg::WALK_ROWS;
   end

   assign accept  = start && !busy_q;
   assign empty   = (rows == '0) || (cols == '0);
   assign row_end = (row_q == rows_q - ROW_W'(1));
   assign col_end = (col_q == cols_q - COL_W'(1));
   assign last    = row_end && col_end;
   assign off     = OFF_W'(row_q) * OFF_W'(cols_q) + OFF_W'(col_q);

   always_comb begin
      row_nx = row_q;
      col_nx = col_q;
      if (walk_eff == ub_pkg::WALK_COLS) begin
         if (row_end) begin
            row_nx = '0;
            col_nx = col_q + 1'b1;
         end else begin
            row_nx = row_q + 1'b1;
         end
      end else begin
         if (col_end) begin
            col_nx = '0;
            row_nx = row_q + 1'b1;
         end else begin
            col_nx = col_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         valid_q <= 1'b0;
         pend_q  <= 1'b0;
         done_q  <= 1'b0;
         row_q   <= '0;
         col_q   <= '0;
         rows_q  <= '0;
         cols_q  <= '0;
         base_q  <= '0;
         sel_q   <= '0;
         tag_q   <= '0;
         walk_q  <= ub_pkg::WALK_ROWS;
      end else begin
         valid_q <= busy_q;
         pend_q  <= (busy_q && last) || (accept && empty);
         done_q  <= pend_q;
         if (busy_q) tag_q <= sel_q;
         if (accept) begin
            busy_q <= !empty;
            row_q  <= '0;
            col_q  <= '0;
            rows_q <= rows;
            cols_q <= cols;
            base_q <= base;
            sel_q  <= sel;
            walk_q <= transpose ? ub_pkg::WALK_COLS : ub_pkg::WALK_ROWS;
         end else if (busy_q) begin
            if (last) busy_q <= 1'b0;
            row_q <= row_nx;
            col_q <= col_nx;
         end
      end
   end

   assign busy  = busy_q;
   assign issue = busy_q;
   assign iaddr = base_q + ADDR_W'(off);
   assign valid = valid_q;
   assign tag   = tag_q;
   assign done  = done_q;

   assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && !start) |=> !valid_q);
   assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> ((row_q < rows_q) && (col_q < cols_q)));
   assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && start) |=> ($stable(base_q) && $stable(rows_q) && $stable(cols_q) && $stable(sel_q)));
   assert_done_apart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !valid_q);
endmodule

// File: rtl/ub_burst_buffer.sv
module ub_burst_buffer #(
   parameter int DEPTH           = 256,
   parameter int DATA_W          = 16,
   parameter int ROW_W           = 8,
   parameter int COL_W           = 2,
   parameter int SEL_W           = 3,
   parameter bit ALLOW_TRANSPOSE = 1'b1,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr1_valid,
   input  logic [DATA_W-1:0] wr1_data,
   input  logic              wr2_valid,
   input  logic [DATA_W-1:0] wr2_data,
   input  logic              rd_start,
   input  logic [ADDR_W-1:0] rd_base,
   input  logic [ROW_W-1:0]  rd_rows,
   input  logic [COL_W-1:0]  rd_cols,
   input  logic              rd_transpose,
   input  logic [SEL_W-1:0]  rd_sel,
   output logic              rd_busy,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [SEL_W-1:0]  rd_tag,
   output logic              rd_to_bias,
   output logic              rd_done
);
   localparam int WR_CH = 2;

   if (SEL_W < 3) begin : g_bad_sel
      $error("ub_burst_buffer: SEL_W must hold the 3-bit bias tag");
   end

   logic [WR_CH-1:0]             we;
   logic [WR_CH-1:0][ADDR_W-1:0] waddr;
   logic [WR_CH-1:0][DATA_W-1:0] wdata;
   logic                         issue;
   logic [ADDR_W-1:0]            iaddr;

   ub_wr_arbiter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_CH(WR_CH)) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .ch_valid ({wr2_valid, wr1_valid}),
      .ch_data  ({wr2_data, wr1_data}),
      .we       (we),
      .waddr    (waddr),
      .wdata    (wdata)
   );

   ub_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W), .WR_CH(WR_CH)) u_mem (
      .clk   (clk),
      .we    (we),
      .waddr (waddr),
      .wdata (wdata),
      .re    (issue),
      .raddr (iaddr),
      .rdata (rd_data)
   );

   ub_rd_seq #(
      .ADDR_W(ADDR_W), .ROW_W(ROW_W), .COL_W(COL_W), .SEL_W(SEL_W),
      .ALLOW_TRANSPOSE(ALLOW_TRANSPOSE)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (rd_start),
      .base      (rd_base),
      .rows      (rd_rows),
      .cols      (rd_cols),
      .transpose (rd_transpose),
      .sel       (rd_sel),
      .busy      (rd_busy),
      .issue     (issue),
      .iaddr     (iaddr),
      .valid     (rd_valid),
      .tag       (rd_tag),
      .done      (rd_done)
   );

   assign rd_to_bias = rd_valid && (rd_tag == SEL_W'(ub_pkg::TAG_BIAS));

   assert_bias_needs_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_to_bias |-> $past(rd_busy));
endmodule

// File: tb/sim_ub_burst_buffer.sv
module sim_ub_burst_buffer;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n;
   logic        wr1_valid, wr2_valid;
   logic [15:0] wr1_data, wr2_data;
   logic        rd_start, rd_transpose;
   logic [7:0]  rd_base, rd_rows;
   logic [1:0]  rd_cols;
   logic [2:0]  rd_sel;
   logic        rd_busy, rd_valid, rd_to_bias, rd_done;
   logic [15:0] rd_data;
   logic [2:0]  rd_tag;

   int total = 0;
   int bad   = 0;
   logic [15:0] model [256];
   logic [7:0]  wp = 8'd0;

   ub_burst_buffer u0 (
      .clk(clk), .rst_n(rst_n),
      .wr1_valid(wr1_valid), .wr1_data(wr1_data),
      .wr2_valid(wr2_valid), .wr2_data(wr2_data),
      .rd_start(rd_start), .rd_base(rd_base), .rd_rows(rd_rows), .rd_cols(rd_cols),
      .rd_transpose(rd_transpose), .rd_sel(rd_sel),
      .rd_busy(rd_busy), .rd_valid(rd_valid), .rd_data(rd_data), .rd_tag(rd_tag),
      .rd_to_bias(rd_to_bias), .rd_done(rd_done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(input bit v1, input logic [15:0] d1, input bit v2, input logic [15:0] d2);
      @(negedge clk);
      wr1_valid = v1; wr1_data = d1; wr2_valid = v2; wr2_data = d2;
      if (v1) begin model[wp] = d1; wp = wp + 8'd1; end
      if (v2) begin model[wp] = d2; wp = wp + 8'd1; end
      @(negedge clk);
      wr1_valid = 1'b0; wr2_valid = 1'b0;
   endtask

   // expected address of burst word k
   function automatic logic [7:0] exp_addr(input int b, input int r, input int c, input bit t, input int k);
      int rr, cc;
      if (t) begin rr = k % r; cc = k / r; end
      else   begin rr = k / c; cc = k % c; end
      return 8'((b + rr * c + cc) % 256);
   endfunction

   // R4 R5 R6 R7 R8 R10 R11: one burst, every word sampled on its own falling edge
   task automatic burst(input int b, input int r, input int c, input bit t, input int s,
                        input string req, input bit poke);
      int n;
      logic [7:0] a;
      n = r * c;
      rd_start = 1'b1; rd_base = 8'(b); rd_rows = 8'(r); rd_cols = 2'(c);
      rd_transpose = t; rd_sel = 3'(s);
      @(negedge clk);
      rd_start = 1'b0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (poke && k == 4) rd_start = 1'b0;
         a = exp_addr(b, r, c, t, k);
         chk(rd_valid === 1'b1, {req, " valid"}, int'(rd_valid), 1);
         chk(rd_data === model[a], {req, " data"}, int'(rd_data), int'(model[a]));
         chk(rd_tag === 3'(s), "R10 tag", int'(rd_tag), s);
         chk(rd_to_bias === (s == 1), "R10 bias", int'(rd_to_bias), int'(s == 1));
         chk(rd_done === 1'b0, "R8 no early done", int'(rd_done), 0);
         if (poke && k == 3) begin
            // R9: start while busy, different burst
            chk(rd_busy === 1'b1, "R9 busy", int'(rd_busy), 1);
            rd_start = 1'b1; rd_base = 8'd200; rd_rows = 8'd2; rd_cols = 2'd1; rd_sel = 3'd5;
         end
      end
      @(negedge clk);
      chk(rd_done === 1'b1, {req, " R8 done"}, int'(rd_done), 1);
      chk(rd_valid === 1'b0, "R7 no extra word", int'(rd_valid), 0);
      @(negedge clk);
      chk(rd_done === 1'b0, "R8 single pulse", int'(rd_done), 0);
      chk(rd_busy === 1'b0, "R8 idle", int'(rd_busy), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      wr1_valid = 1'b0; wr2_valid = 1'b0; wr1_data = '0; wr2_data = '0;
      rd_start = 1'b0; rd_base = '0; rd_rows = '0; rd_cols = '0; rd_transpose = 1'b0; rd_sel = '0;
      repeat (3) @(negedge clk);
      chk(rd_valid === 1'b0 && rd_done === 1'b0 && rd_busy === 1'b0 && rd_to_bias === 1'b0,
          "R1 reset", int'({rd_valid, rd_done, rd_busy, rd_to_bias}), 0);
      rst_n = 1'b1;

      // R3: fill all entries with paired writes
      for (int i = 0; i < 128; i++)
         wr(1'b1, 16'((2*i) * 257) ^ 16'h5A3C, 1'b1, 16'((2*i+1) * 257) ^ 16'h5A3C);
      burst(0, 2, 3, 1'b0, 0, "R3", 1'b0);
      burst(250, 2, 3, 1'b0, 1, "R3", 1'b0);

      // R2: single-channel writes after the pointer wrapped to 0
      wr(1'b1, 16'hBEEF, 1'b0, 16'h0000);
      wr(1'b0, 16'h0000, 1'b1, 16'hCAFE);
      wr(1'b1, 16'h1111, 1'b1, 16'h2222);
      burst(0, 1, 3, 1'b0, 2, "R2", 1'b0);
      burst(3, 1, 1, 1'b0, 3, "R3", 1'b0);

      // R5 R6 R7 sweep: rows x cols x order
      for (int ri = 0; ri < 4; ri++) begin
         for (int c = 0; c < 4; c++) begin
            for (int t = 0; t < 2; t++) begin
               int r;
               r = (ri == 0) ? 0 : (ri == 1) ? 1 : (ri == 2) ? 3 : 6;
               burst((ri * 61 + c * 23 + t * 7 + 9) % 256, r, c, t[0], (ri + c + t) % 8,
                     t ? "R6" : "R5", 1'b0);
            end
         end
      end

      // R11: wrap past the top entry, both orders
      burst(254, 3, 3, 1'b0, 1, "R11", 1'b0);
      burst(253, 4, 2, 1'b1, 4, "R11", 1'b0);

      // R9: start during a running burst is ignored
      burst(10, 4, 3, 1'b0, 2, "R9", 1'b1);
      rd_start = 1'b0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(rd_valid === 1'b0 && rd_done === 1'b0, "R9 no follow-on burst",
             int'({rd_valid, rd_done}), 0);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule